// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a memory access request into a 20-bit physical byte address for a segmented 16-bit address space. The caller supplies the four segment register values, the instruction pointer, the four address-capable general registers (BX, BP, SI, DI), a 16-bit displacement and a description of the addressing form. It also supplies whether the access is an instruction fetch or a data operand access, and an optional segment override. The block forms the 16-bit offset, picks the segment that applies, and adds the segment value, moved up by four bit positions, to the offset.

The addressing form is given as three fields: a base choice (none, BX or BP), an index choice (none, SI or DI), and a flag that adds the displacement. Every supported form is a combination of these fields. A lone displacement is direct addressing, and a single register is register-indirect addressing. Base plus index, with or without the displacement, covers the based-indexed forms.

Results are registered. One cycle after a request, the offset, the segment number and the physical address appear together with a valid flag. With no request, the previous result is held.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it, out_valid is 0 and out_ea, out_seg and out_phys are all zero.
- R2: out_valid is 1 in the cycle after a cycle with req_valid high, and 0 in the cycle after a cycle with req_valid low.
- R3: In the cycle after a cycle with req_valid low, out_ea, out_seg and out_phys keep their values, whatever the other inputs do.
- R4: A fetch request (req_fetch=1) reports segment code 1 (CS) and uses ip as the offset. ovr_en, ovr_seg and the addressing fields have no effect on a fetch.
- R5: A data request (req_fetch=0) forms the offset as base + index + (ea_disp_en ? disp : 0). ea_base is 0 for none, 1 for BX, 2 for BP and 3 for none. ea_index is 0 for none, 1 for SI, 2 for DI and 3 for none.
- R6: The offset sum wraps modulo 2^16 before the segment is added.
- R7: Segment codes are 0 ES, 1 CS, 2 SS and 3 DS. Without an override, a data request uses DS (3), or SS (2) when ea_base selects BP.
- R8: With ovr_en=1, a data request uses the segment coded on ovr_seg, replacing the default, including the BP case.
- R9: out_phys equals the selected segment value times 16 plus out_ea, modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| ip | input | 16 | Instruction pointer |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| disp | input | 16 | Displacement |
| ea_base | input | 2 | Base choice: 0 none, 1 BX, 2 BP, 3 none |
| ea_index | input | 2 | Index choice: 0 none, 1 SI, 2 DI, 3 none |
| ea_disp_en | input | 1 | Add the displacement |
| ovr_en | input | 1 | Segment override active |
| ovr_seg | input | 2 | Override segment code (0 ES, 1 CS, 2 SS, 3 DS) |
| out_valid | output | 1 | Registered result valid |
| out_ea | output | 16 | Registered offset |
| out_seg | output | 2 | Registered segment code |
| out_phys | output | 20 | Registered physical address |

## Verification
The assertions assume that the segment, pointer, register and mode inputs matter only in a cycle where req_valid is high, and that the reserved field codes are legal encodings that mean "no register". They make no assumption that these inputs stay stable across cycles. The stimulus therefore changes every input during idle cycles to show that nothing leaks through. It drives the reserved codes, turns on the override during fetches, and picks register and segment values near 0xFFFF so that both wrap points are reached.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        BASE_NONE = 2'd0,
        BASE_BX   = 2'd1,
        BASE_BP   = 2'd2,
        BASE_RSVD = 2'd3
    } base_sel_e;

    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,
        IDX_SI   = 2'd1,
        IDX_DI   = 2'd2,
        IDX_RSVD = 2'd3
    } index_sel_e;

endpackage

// File: rtl/ea_calc.sv
module ea_calc
    import seg_addr_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  base_sel_e        base_sel,
    input  index_sel_e       index_sel,
    input  logic             disp_en,
    input  logic [OFF_W-1:0] bx_val,
    input  logic [OFF_W-1:0] bp_val,
    input  logic [OFF_W-1:0] si_val,
    input  logic [OFF_W-1:0] di_val,
    input  logic [OFF_W-1:0] disp_val,
    output logic [OFF_W-1:0] ea,
    output logic             base_is_bp
);

    logic [OFF_W-1:0] base_term;
    logic [OFF_W-1:0] index_term;
    logic [OFF_W-1:0] disp_term;

    always_comb begin
        unique case (base_sel)
            BASE_BX: base_term = bx_val;
            BASE_BP: base_term = bp_val;
            default: base_term = '0;
        endcase
    end

    always_comb begin
        unique case (index_sel)
            IDX_SI:  index_term = si_val;
            IDX_DI:  index_term = di_val;
            default: index_term = '0;
        endcase
    end

    assign disp_term  = disp_en ? disp_val : '0;
    // Three-operand sum kept at OFF_W bits: the carry out is discarded (R6).
    assign ea         = base_term + index_term + disp_term;
    assign base_is_bp = (base_sel == BASE_BP);

endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_addr_pkg::*;
(
    input  logic    is_fetch,
    input  logic    base_is_bp,
    input  logic    ovr_en,
    input  seg_id_e ovr_seg,
    output seg_id_e seg_sel
);

    seg_id_e data_default;

    always_comb begin
        data_default = base_is_bp ? SEG_SS : SEG_DS;
        if (is_fetch) begin
            seg_sel = SEG_CS;
        end else if (ovr_en) begin
            seg_sel = ovr_seg;
        end else begin
            seg_sel = data_default;
        end
    end

endmodule

// File: rtl/phys_adder.sv
module phys_adder #(
    parameter int OFF_W = 16,
    parameter int SHIFT = 4
) (
    input  logic [OFF_W-1:0]       seg_val,
    input  logic [OFF_W-1:0]       offset,
    output logic [OFF_W+SHIFT-1:0] phys
);

    localparam int PHYS_W = OFF_W + SHIFT;

    logic [PHYS_W-1:0] seg_term;
    logic [PHYS_W-1:0] off_term;

    assign seg_term = {seg_val, {SHIFT{1'b0}}};
    assign off_term = {{SHIFT{1'b0}}, offset};
    // The sum has PHYS_W bits, so it wraps modulo 2^PHYS_W (R9).
    assign phys     = seg_term + off_term;

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int OFF_W = 16,
    parameter int SHIFT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_fetch,
    input  logic [OFF_W-1:0]       seg_es,
    input  logic [OFF_W-1:0]       seg_cs,
    input  logic [OFF_W-1:0]       seg_ss,
    input  logic [OFF_W-1:0]       seg_ds,
    input  logic [OFF_W-1:0]       ip,
    input  logic [OFF_W-1:0]       reg_bx,
    input  logic [OFF_W-1:0]       reg_bp,
    input  logic [OFF_W-1:0]       reg_si,
    input  logic [OFF_W-1:0]       reg_di,
    input  logic [OFF_W-1:0]       disp,
    input  logic [1:0]             ea_base,
    input  logic [1:0]             ea_index,
    input  logic                   ea_disp_en,
    input  logic                   ovr_en,
    input  logic [1:0]             ovr_seg,
    output logic                   out_valid,
    output logic [OFF_W-1:0]       out_ea,
    output logic [1:0]             out_seg,
    output logic [OFF_W+SHIFT-1:0] out_phys
);

    localparam int PHYS_W = OFF_W + SHIFT;
    localparam int NSEG   = 4;

    typedef struct packed {
        logic              valid;
        logic [OFF_W-1:0]  ea;
        seg_id_e           seg;
        logic [PHYS_W-1:0] phys;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [OFF_W-1:0]  data_ea_d;
    logic              base_is_bp_d;
    seg_id_e           seg_sel_d;
    logic [OFF_W-1:0]  seg_val_d;
    logic [OFF_W-1:0]  offset_d;
    logic [PHYS_W-1:0] phys_d;
    logic [OFF_W-1:0]  seg_bank [NSEG];

    assign seg_bank[SEG_ES] = seg_es;
    assign seg_bank[SEG_CS] = seg_cs;
    assign seg_bank[SEG_SS] = seg_ss;
    assign seg_bank[SEG_DS] = seg_ds;

    ea_calc #(.OFF_W(OFF_W)) u_ea_calc (
        .base_sel   (base_sel_e'(ea_base)),
        .index_sel  (index_sel_e'(ea_index)),
        .disp_en    (ea_disp_en),
        .bx_val     (reg_bx),
        .bp_val     (reg_bp),
        .si_val     (reg_si),
        .di_val     (reg_di),
        .disp_val   (disp),
        .ea         (data_ea_d),
        .base_is_bp (base_is_bp_d)
    );

    seg_select u_seg_select (
        .is_fetch   (req_fetch),
        .base_is_bp (base_is_bp_d),
        .ovr_en     (ovr_en),
        .ovr_seg    (seg_id_e'(ovr_seg)),
        .seg_sel    (seg_sel_d)
    );

    assign seg_val_d = seg_bank[seg_sel_d];
    assign offset_d  = req_fetch ? ip : data_ea_d;

    phys_adder #(.OFF_W(OFF_W), .SHIFT(SHIFT)) u_phys_adder (
        .seg_val (seg_val_d),
        .offset  (offset_d),
        .phys    (phys_d)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        if (req_valid) begin
            st_d.ea   = offset_d;
            st_d.seg  = seg_sel_d;
            st_d.phys = phys_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_ea    = st_q.ea;
    assign out_seg   = st_q.seg;
    assign out_phys  = st_q.phys;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    a_r2_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(out_ea) && $stable(out_seg) && $stable(out_phys)));

    a_r4_fetch_uses_cs_ip: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fetch) |=> (out_seg == 2'd1 && out_ea == $past(ip)));

    a_r7_bp_defaults_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_fetch && !ovr_en && ea_base == 2'd2) |=> (out_seg == 2'd2));

    a_r8_override_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_fetch && ovr_en) |=> (out_seg == $past(ovr_seg)));

    a_r9_low_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_phys[SHIFT-1:0] == out_ea[SHIFT-1:0]));

endmodule

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_fetch;
    logic [15:0] seg_es, seg_cs, seg_ss, seg_ds, ip;
    logic [15:0] reg_bx, reg_bp, reg_si, reg_di, disp;
    logic [1:0]  ea_base, ea_index, ovr_seg;
    logic        ea_disp_en, ovr_en;
    logic        out_valid;
    logic [15:0] out_ea;
    logic [1:0]  out_seg;
    logic [19:0] out_phys;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    int    exp_valid = 0, exp_ea = 0, exp_seg = 0, exp_phys = 0;
    string tag_valid = "R1", tag_ea = "R1", tag_seg = "R1", tag_phys = "R1";

    always #4 clk = ~clk;

    seg_addr_gen u_seg_addr_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fetch(req_fetch),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .ip(ip), .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si),
        .reg_di(reg_di), .disp(disp), .ea_base(ea_base), .ea_index(ea_index),
        .ea_disp_en(ea_disp_en), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
        .out_valid(out_valid), .out_ea(out_ea), .out_seg(out_seg), .out_phys(out_phys)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        chk(tag_valid, "out_valid", int'(out_valid), exp_valid);
        chk(tag_ea,    "out_ea",    int'(out_ea),    exp_ea);
        chk(tag_seg,   "out_seg",   int'(out_seg),   exp_seg);
        chk(tag_phys,  "out_phys",  int'(out_phys),  exp_phys);
    endtask

    function automatic int seg_value(input int code);
        case (code)
            0: return int'(seg_es);
            1: return int'(seg_cs);
            2: return int'(seg_ss);
            default: return int'(seg_ds);
        endcase
    endfunction

    // Behavioural reference: builds the expectation for the next cycle.
    task automatic model();
        int b, i, d, sum, sv;
        tag_valid = "R2";
        if (!req_valid) begin
            exp_valid = 0;
            tag_ea = "R3"; tag_seg = "R3"; tag_phys = "R3";
            return;
        end
        exp_valid = 1;
        if (req_fetch) begin
            exp_seg = 1; exp_ea = int'(ip);
            tag_ea = "R4"; tag_seg = "R4";
        end else begin
            b = (ea_base == 2'd1) ? int'(reg_bx) : (ea_base == 2'd2) ? int'(reg_bp) : 0;
            i = (ea_index == 2'd1) ? int'(reg_si) : (ea_index == 2'd2) ? int'(reg_di) : 0;
            d = ea_disp_en ? int'(disp) : 0;
            sum = b + i + d;
            exp_ea = sum % 65536;
            tag_ea = (sum > 65535) ? "R6" : "R5";
            if (ovr_en) begin
                exp_seg = int'(ovr_seg); tag_seg = "R8";
            end else begin
                exp_seg = (ea_base == 2'd2) ? 2 : 3; tag_seg = "R7";
            end
        end
        sv = seg_value(exp_seg);
        exp_phys = (sv * 16 + exp_ea) % 1048576;
        tag_phys = "R9";
    endtask

    task automatic step();
        model();
        @(negedge clk);
        compare_all();
    endtask

    task automatic randomize_inputs(input bit allow_idle);
        req_valid  = allow_idle ? ($urandom_range(0, 3) != 0) : 1'b1;
        req_fetch  = ($urandom_range(0, 4) == 0);
        seg_es = 16'($urandom); seg_cs = 16'($urandom);
        seg_ss = 16'($urandom); seg_ds = 16'($urandom);
        ip     = 16'($urandom); disp   = 16'($urandom);
        reg_bx = 16'($urandom); reg_bp = 16'($urandom);
        reg_si = 16'($urandom); reg_di = 16'($urandom);
        ea_base    = 2'($urandom); ea_index = 2'($urandom);
        ea_disp_en = 1'($urandom); ovr_en   = ($urandom_range(0, 2) == 0);
        ovr_seg    = 2'($urandom);
    endtask

    task automatic data_req(input int base, input int idx, input bit den, input bit oe, input int os);
        req_valid = 1'b1; req_fetch = 1'b0;
        ea_base = 2'(base); ea_index = 2'(idx); ea_disp_en = den;
        ovr_en = oe; ovr_seg = 2'(os);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_fetch = 1'b0;
        seg_es = 16'h0CF0; seg_cs = 16'h0FF0; seg_ss = 16'h0B20; seg_ds = 16'h0100;
        ip = 16'h0056; reg_bx = 16'h1000; reg_bp = 16'h2000; reg_si = 16'h0030;
        reg_di = 16'h0004; disp = 16'h0050;
        ea_base = 2'd0; ea_index = 2'd0; ea_disp_en = 1'b0; ovr_en = 1'b0; ovr_seg = 2'd0;

        // R1: outputs cleared under reset, even with a request present
        repeat (2) @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        compare_all();
        req_valid = 1'b0;
        rst_n = 1'b1;
        step();

        // R4: fetch, with override and modes set, must still use CS:IP
        req_valid = 1'b1; req_fetch = 1'b1; ovr_en = 1'b1; ovr_seg = 2'd0;
        ea_base = 2'd2; step();

        // R5: direct displacement (reserved codes mean no register), DS
        data_req(3, 3, 1, 0, 0); step();
        // R5/R7: BX alone, SI alone, DI plus displacement
        data_req(1, 0, 0, 0, 0); step();
        data_req(0, 1, 0, 0, 0); step();
        data_req(0, 2, 1, 0, 0); step();
        // R7: BP-based forms default to SS
        data_req(2, 0, 0, 0, 0); step();
        data_req(2, 2, 1, 0, 0); step();
        // R5: BX+SI+disp in DS
        data_req(1, 1, 1, 0, 0); step();
        // R8: override replaces the BP default, and the DS default
        data_req(2, 1, 0, 1, 0); step();
        data_req(1, 2, 1, 1, 1); step();

        // R6: offset wraps modulo 2^16
        reg_bx = 16'hFFFF; reg_di = 16'h0003; disp = 16'hFFF0;
        data_req(1, 2, 1, 0, 0); step();
        // R9: physical sum wraps modulo 2^20
        seg_ds = 16'hFFFF; reg_bx = 16'hFFFF;
        data_req(1, 0, 0, 0, 0); step();

        // R3: idle cycles with every other input changed
        for (int k = 0; k < 3; k++) begin
            randomize_inputs(1'b0);
            req_valid = 1'b0;
            step();
        end

        // Mixed traffic compared every clock
        for (int n = 0; n < 2000; n++) begin
            randomize_inputs(1'b1);
            step();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule